// File: doc/BRIEF.md
# Errored Second Monitor and Timer

This block keeps a one-second view of receive quality for a four-channel T1/J1 line receiver. Each channel gets a one-cycle tick once per second. The tick comes either from the channel's own programmable clock divider or, when a single global select is set, from one external second pulse that all channels share. That pulse passes through a two-flop synchronizer and a rising-edge detector before any channel uses it.

Between ticks, each channel gathers seven kinds of error event. A per-event mask decides which kinds count. When a tick closes an interval that contained at least one counted event, the channel raises its errored-second interrupt flag. Every tick also raises a one-second timer interrupt flag, which tells software to look at its status bits and error counters. Both flags are cleared when read. Any one channel's tick can be driven onto a shared output pin, and an enable gates that pin.

Top module: `es_monitor`

## Requirements
- R1: While `rst` is high, and at the first falling edge after it rises, `sec_tick`, `es_irq`, `sec_irq` and `sec_out` are all zero.
- R2: With `ext_sel` low and `div_limit` = L (L ≥ 1), every channel's `sec_tick` is a one-cycle pulse. After reset is released, the first pulse is high during the cycle that follows the L-th rising clock edge, and pulses then repeat every L+1 cycles.
- R3: With `ext_sel` high, the internal dividers do not tick. Suppose a rising edge of `ext_sec_in` is first sampled at clock edge r. Then all four bits of `sec_tick` are high together for exactly one cycle, between edges r+1 and r+2. An input held high produces no further ticks.
- R4: An event whose mask bit in `ev_mask` is 0 has no effect on `es_irq`.
- R5: `es_irq[c]` is set on the clock edge that ends a tick cycle of channel c if any enabled event of channel c occurred in that interval. The interval runs from the cycle after the previous tick up to and including the tick cycle. `es_irq[c]` is never set at any other time.
- R6: Each tick starts a new interval. A tick that closes an interval with no enabled event does not set `es_irq`.
- R7: On the edge that ends a tick cycle of channel c, `sec_irq[c]` is set.
- R8: `rd_clr[c]` high for a cycle clears `es_irq[c]` and `sec_irq[c]` at the next edge. If a flag is set at that same edge, the set wins and the flag stays 1.
- R9: `sec_out` equals `sec_tick[out_sel]` when `out_en` is 1, and is 0 when `out_en` is 0.
- R10: Bit c*7+k of `ev_in` and of `ev_mask` belongs to channel c and event kind k, where k is 0 framing error, 1 CRC error, 2 code violation, 3 frame alignment loss, 4 signal loss, 5 alarm indication signal, 6 slip. An event and its mask bit affect only their own channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_sel | input | 1 | 1: all channels tick from the external pulse |
| ext_sec_in | input | 1 | External second pulse, asynchronous |
| div_limit | input | DIV_W | Internal divider terminal count (period = value + 1 cycles) |
| ev_in | input | NUM_CH*7 | Event pulses, channel-major, 7 kinds per channel |
| ev_mask | input | NUM_CH*7 | Per-event enable, 1 = counted |
| rd_clr | input | NUM_CH | Per-channel read strobe that clears both flags |
| out_sel | input | $clog2(NUM_CH) | Channel whose tick drives the pin |
| out_en | input | 1 | Enable for the tick pin |
| sec_tick | output | NUM_CH | Per-channel one-second tick |
| es_irq | output | NUM_CH | Errored-second interrupt flags |
| sec_irq | output | NUM_CH | One-second timer interrupt flags |
| sec_out | output | 1 | Selected tick on the shared pin |

## Verification
An internal tick is due combinationally in the cycle after edge count L, 2L+1 and so on from reset release. An external tick is due two edges after the edge that first sees the pin high. Both interrupt flags change one edge after a tick or a read strobe, and `sec_out` follows the selected tick in the same cycle. The bench drives every input one nanosecond after a falling edge and compares all outputs at the next falling edge. At that point every register has settled. Its reference counts edges since reset and records the edge index of each external rising edge, so each expected tick comes from arithmetic on those counts rather than from a copy of the registers.

// File: rtl/es_pkg.sv
package es_pkg;

    localparam int unsigned EV_KINDS = 7;

    typedef enum logic [2:0] {
        EVK_FRAMING  = 3'd0,
        EVK_CRC      = 3'd1,
        EVK_CODEVIOL = 3'd2,
        EVK_ALIGN    = 3'd3,
        EVK_SIGLOSS  = 3'd4,
        EVK_AIS      = 3'd5,
        EVK_SLIP     = 3'd6
    } ev_kind_e;

    typedef logic [EV_KINDS-1:0] ev_vec_t;

    typedef struct packed {
        logic pending;   // enabled event seen in current interval
        logic es_flag;   // errored-second interrupt
        logic sec_flag;  // one-second timer interrupt
    } chan_state_t;

    function automatic logic counted_event(input ev_vec_t ev, input ev_vec_t mask);
        return |(ev & mask);
    endfunction

endpackage

// File: rtl/es_sec_timer.sv
module es_sec_timer #(
    parameter int unsigned DIV_W = 27
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);
    logic [DIV_W-1:0] count_q;
    logic             at_end;

    assign at_end = (count_q >= limit);
    assign tick   = !hold && at_end;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            count_q <= '0;
        end else if (at_end) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/es_ext_sync.sv
module es_ext_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic tick
);
    logic [2:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[1:0], pin};
        end
    end

    // stage_q[1] is the second synchronizer flop, stage_q[2] its delayed copy
    assign tick = stage_q[1] && !stage_q[2];
endmodule

// File: rtl/es_chan.sv
module es_chan
    import es_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  ev_vec_t ev,
    input  ev_vec_t mask,
    input  logic    rd_clr,
    output logic    es_flag,
    output logic    sec_flag
);
    chan_state_t st_q, st_d;
    logic        hit;

    assign hit = counted_event(ev, mask);

    always_comb begin
        st_d          = st_q;
        st_d.pending  = tick ? 1'b0 : (st_q.pending || hit);
        st_d.es_flag  = (st_q.es_flag && !rd_clr) || (tick && (st_q.pending || hit));
        st_d.sec_flag = (st_q.sec_flag && !rd_clr) || tick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign es_flag  = st_q.es_flag;
    assign sec_flag = st_q.sec_flag;
endmodule

// File: rtl/es_monitor.sv
module es_monitor
    import es_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DIV_W  = 27,
    localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned EV_W  = NUM_CH * EV_KINDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_sel,
    input  logic              ext_sec_in,
    input  logic [DIV_W-1:0]  div_limit,
    input  logic [EV_W-1:0]   ev_in,
    input  logic [EV_W-1:0]   ev_mask,
    input  logic [NUM_CH-1:0] rd_clr,
    input  logic [SEL_W-1:0]  out_sel,
    input  logic              out_en,
    output logic [NUM_CH-1:0] sec_tick,
    output logic [NUM_CH-1:0] es_irq,
    output logic [NUM_CH-1:0] sec_irq,
    output logic              sec_out
);
    logic ext_tick;

    es_ext_sync u_ext (
        .clk  (clk),
        .rst  (rst),
        .pin  (ext_sec_in),
        .tick (ext_tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic int_tick;

        es_sec_timer #(.DIV_W(DIV_W)) u_timer (
            .clk   (clk),
            .rst   (rst),
            .hold  (ext_sel),
            .limit (div_limit),
            .tick  (int_tick)
        );

        assign sec_tick[c] = ext_sel ? ext_tick : int_tick;

        es_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .tick     (sec_tick[c]),
            .ev       (ev_in[c*EV_KINDS +: EV_KINDS]),
            .mask     (ev_mask[c*EV_KINDS +: EV_KINDS]),
            .rd_clr   (rd_clr[c]),
            .es_flag  (es_irq[c]),
            .sec_flag (sec_irq[c])
        );
    end

    assign sec_out = out_en && sec_tick[out_sel];
endmodule

// File: rtl/es_monitor_chk.sv
module es_monitor_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DIV_W  = 27,
    parameter int unsigned SEL_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              ext_sel,
    input logic [DIV_W-1:0]  div_limit,
    input logic [NUM_CH-1:0] rd_clr,
    input logic              out_en,
    input logic [NUM_CH-1:0] sec_tick,
    input logic [NUM_CH-1:0] es_irq,
    input logic [NUM_CH-1:0] sec_irq,
    input logic              sec_out
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_a
        assert_tick_sets_irq_R7: assert property (@(posedge clk) disable iff (rst)
            sec_tick[c] |=> sec_irq[c]);

        assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
            (rd_clr[c] && !sec_tick[c]) |=> (!sec_irq[c] && !es_irq[c]));

        assert_es_only_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(es_irq[c]) |-> $past(sec_tick[c]));
    end

    assert_ext_lockstep_R3: assert property (@(posedge clk) disable iff (rst)
        ext_sel |-> (sec_tick == '0 || sec_tick == '1));

    assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
        (sec_tick[0] && (ext_sel || div_limit != '0))
        |=> (!sec_tick[0] || !$stable(ext_sel) || !$stable(div_limit)));

    assert_pin_gated_R9: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> !sec_out);
endmodule

bind es_monitor es_monitor_chk #(
    .NUM_CH (NUM_CH),
    .DIV_W  (DIV_W),
    .SEL_W  (SEL_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ext_sel   (ext_sel),
    .div_limit (div_limit),
    .rd_clr    (rd_clr),
    .out_en    (out_en),
    .sec_tick  (sec_tick),
    .es_irq    (es_irq),
    .sec_irq   (sec_irq),
    .sec_out   (sec_out)
);

// File: tb/es_monitor_test.sv
module es_monitor_test;
    localparam int NCH = 4;
    localparam int NEV = 7;
    localparam int DW  = 27;
    localparam int EW  = NCH * NEV;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           ext_sel = 1'b0;
    logic           ext_sec_in = 1'b0;
    logic [DW-1:0]  div_limit = 27'd1;
    logic [EW-1:0]  ev_in = '0;
    logic [EW-1:0]  ev_mask = '0;
    logic [NCH-1:0] rd_clr = '0;
    logic [1:0]     out_sel = '0;
    logic           out_en = 1'b0;
    logic [NCH-1:0] sec_tick, es_irq, sec_irq;
    logic           sec_out;

    es_monitor uut (
        .clk(clk), .rst(rst), .ext_sel(ext_sel), .ext_sec_in(ext_sec_in),
        .div_limit(div_limit), .ev_in(ev_in), .ev_mask(ev_mask), .rd_clr(rd_clr),
        .out_sel(out_sel), .out_en(out_en), .sec_tick(sec_tick), .es_irq(es_irq),
        .sec_irq(sec_irq), .sec_out(sec_out)
    );

    always #5 clk = ~clk;

    int nchk = 0, nfail = 0, cyc = 0;
    bit done = 0;
    logic [31:0] rng = 32'h1234_5678;

    // reference state
    int kcnt = 0, rise_at = -100;
    logic prev_ext = 1'b0;
    logic [NCH-1:0] m_acc = '0, m_es = '0, m_sec = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_tick();
        if (ext_sel) return (kcnt == rise_at + 1);
        return (kcnt % (int'(div_limit) + 1)) == int'(div_limit);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            kcnt = 0; rise_at = -100; prev_ext = 1'b0;
            m_acc = '0; m_es = '0; m_sec = '0;
        end else begin
            logic t;
            t = exp_tick();
            for (int c = 0; c < NCH; c++) begin
                logic hit;
                hit = |(ev_in[c*NEV +: NEV] & ev_mask[c*NEV +: NEV]);
                m_es[c]  = (m_es[c] & ~rd_clr[c]) | (t & (m_acc[c] | hit));
                m_sec[c] = (m_sec[c] & ~rd_clr[c]) | t;
                m_acc[c] = t ? 1'b0 : (m_acc[c] | hit);
            end
            kcnt++;
            if (ext_sec_in && !prev_ext) rise_at = kcnt;
            prev_ext = ext_sec_in;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            logic t;
            t = exp_tick();
            chk(ext_sel ? "R3 sec_tick" : "R2 sec_tick", 32'(sec_tick), t ? 32'hF : 32'h0);
            chk("R5 es_irq", 32'(es_irq), 32'(m_es));
            chk("R7 sec_irq", 32'(sec_irq), 32'(m_sec));
            chk("R9 sec_out", 32'(sec_out), 32'(out_en & t));
        end
    end

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            nchk++; nfail++;
            $display("FAIL watchdog R2 actual=%0d expected=<100000", cyc);
            finish_run();
        end
    end

    task automatic step_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
    endtask

    task automatic do_reset(input int lim, input logic ext);
        @(negedge clk); #1;
        rst = 1'b1; div_limit = DW'(lim); ext_sel = ext;
        ev_in = '0; rd_clr = '0; ext_sec_in = 1'b0;
        repeat (2) @(negedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic random_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            step_rng();
            ev_in  = (rng[31:29] == 3'd0) ? EW'(rng) : '0;
            step_rng();
            rd_clr = rng[3:0] & rng[7:4];
            out_en = rng[8];
            out_sel = rng[10:9];
        end
        @(negedge clk); #1;
        ev_in = '0; rd_clr = '0;
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (sec_tick[0] !== 1'b1);
    endtask

    task automatic pulse_clr();
        #1 rd_clr = '1;
        @(negedge clk); #1 rd_clr = '0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1 sec_tick", 32'(sec_tick), 0);
        chk("R1 es_irq", 32'(es_irq), 0);
        chk("R1 sec_irq", 32'(sec_irq), 0);
        chk("R1 sec_out", 32'(sec_out), 0);

        // sweep of divider limits (R2, R5, R7, R8, R9)
        foreach (rng[i]) if (i < 5) begin
            int lims[5] = '{1, 2, 3, 4, 6};
            do_reset(lims[i], 1'b0);
            step_rng();
            ev_mask = EW'(rng) | EW'(rng >> 3);
            random_cycles(10 * (lims[i] + 1));
        end

        // external mode (R3)
        do_reset(2, 1'b1);
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (sec_tick != '0) seen++;
            end
            chk("R3 internal held", 32'(seen), 0);
        end
        #1 ext_sec_in = 1'b1;
        @(negedge clk); chk("R3 not yet", 32'(sec_tick), 0);
        @(negedge clk); chk("R3 tick all", 32'(sec_tick), 32'hF);
        @(negedge clk); chk("R3 one cycle", 32'(sec_tick), 0);
        repeat (4) @(negedge clk);
        chk("R3 held high", 32'(sec_tick), 0);
        #1 ext_sec_in = 1'b0;
        ev_mask = '1;
        for (int p = 0; p < 6; p++) begin
            repeat (1 + p % 3) begin @(negedge clk); #1 ext_sec_in = 1'b1; ev_in = EW'(1) << (p * 4); end
            @(negedge clk); #1 ext_sec_in = 1'b0; ev_in = '0;
            repeat (10) @(negedge clk);
        end

        // directed internal checks, L = 3
        do_reset(3, 1'b0);
        ev_mask = '1;
        // R4: all events masked
        wait_tick();
        @(negedge clk); #1 rd_clr = '1; ev_mask = '0; ev_in = '1;
        @(negedge clk); #1 rd_clr = '0;
        wait_tick();
        @(negedge clk);
        chk("R4 masked events", 32'(es_irq), 0);
        #1 ev_in = '0;
        // R10: channel 2 signal-loss bit (2*7+4 = 18) only
        ev_mask = EW'(1) << 18;
        ev_in = (EW'(1) << 18) | (EW'(1) << 17) | (EW'(1) << 4);
        @(negedge clk); #1 ev_in = '0;
        wait_tick();
        @(negedge clk);
        chk("R10 lane mapping", 32'(es_irq), 32'h4);
        pulse_clr();
        chk("R8 read clears", 32'(es_irq), 0);
        // R5: event in the tick cycle closes into that interval
        ev_mask = '1;
        wait_tick();
        #1 ev_in = EW'(1) << 7;
        @(negedge clk); #1 ev_in = '0;
        chk("R5 tick-cycle event", 32'(es_irq), 32'h2);
        chk("R7 timer flag", 32'(sec_irq), 32'hF);
        // R6: quiet interval
        pulse_clr();
        wait_tick();
        @(negedge clk);
        chk("R6 quiet interval", 32'(es_irq), 0);
        chk("R7 timer flag again", 32'(sec_irq), 32'hF);
        // R8: set wins over clear in the same cycle
        #1 ev_in = EW'(1) << 14;
        @(negedge clk); #1 ev_in = '0;
        wait_tick();
        #1 rd_clr = '1;
        @(negedge clk); #1 rd_clr = '0;
        chk("R8 set wins es", 32'(es_irq), 32'h4);
        chk("R8 set wins sec", 32'(sec_irq), 32'hF);
        pulse_clr();
        chk("R8 cleared es", 32'(es_irq), 0);
        chk("R8 cleared sec", 32'(sec_irq), 0);
        // R9: pin gating
        out_en = 1'b0; out_sel = 2'd2;
        wait_tick();
        chk("R9 pin off", 32'(sec_out), 0);
        #1 out_en = 1'b1;
        wait_tick();
        chk("R9 pin on", 32'(sec_out), 1);
        @(negedge clk);
        chk("R9 pin idle", 32'(sec_out), 0);

        finish_run();
    end
endmodule